// File: doc/BRIEF.md
# Edge-Selectable Four-Channel Input Capture

This block records when edges occur on up to four external signals. A single free-running counter advances on a tick that divides the core clock by a programmable factor. Each channel first passes its input through a two-stage synchronizer. On a qualifying transition, the channel stores the current counter value in its own capture register and sets its own pending flag.

Each channel selects its qualifying edge through a 2-bit mode: none, rising, falling or either. Host software typically arms rising, then flips the mode after each capture. The difference between two stored values gives high time, and three values give the period. A master enable gates all channels. Per-channel interrupt enables mask the pending flags onto one combined interrupt line. An acknowledge register clears pending flags.

Access is a simple word-addressed register port with a write strobe and a combinational read. Register offsets are fixed because host software decodes them.

Top module: `edge_capture_unit`

## Requirements
- R1: After `rst_n` is asserted, every register reads zero and `irq` is low. The block leaves reset on the second clock edge after `rst_n` rises.
- R2: A capture is taken on the third rising clock edge after the input changes: two synchronizer stages plus the latch. After only two edges, the pending flag is still clear.
- R3: The counter increments once every (P+1) clock cycles, where P is control register 0x50 bits 8:4. It wraps modulo 2^CNT_W and runs whether or not capture is enabled.
- R4: The capture register of channel n reads at 0x10+4n. It holds the counter value from the latching edge and keeps it until the next capture on that channel.
- R5: The edge mode of channel n is bits 1:0 at 0x30+4n. The encodings are 0 = no edge, 1 = rising, 2 = falling, 3 = either.
- R6: Control register 0x50 bit 10 is the master enable. While it is 0, no channel captures and no flag rises.
- R7: The pending flag of channel n is bit n+1 of 0x58. It stays set until acknowledged. A write to 0x5C clears each flag whose bit in the write data is 1, so 0x1FF clears all of them.
- R8: `irq` is high exactly when some channel has its pending flag set and its enable set. The enable of channel n is bit n+1 of 0x54.
- R9: A capture on the same clock edge as an acknowledge of that channel leaves its flag set.
- R10: Channels act independently. An edge on one channel changes no other channel's flag or capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | NUM_CH | Asynchronous signals to timestamp |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bound checker watches several rules on every cycle:
- The counter only ever steps by one.
- A capture register changes only on its channel's hit.
- A flag rises only after a hit that occurred while the master enable and a nonzero mode were in force.
- An acknowledge without a simultaneous hit clears the flag, and a hit always leaves the flag set.

Only the bench scenarios can show the rest:
- The exact latency from input change to capture.
- The correctness of stored timestamps against an independent counter model, and the tick count across prescale settings and counter wrap.
- The full mode-by-direction truth table on every channel.
- The masking of `irq` by the enable register.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam logic [7:0] OFS_VALUE = 8'h10;
  localparam logic [7:0] OFS_EDGE  = 8'h30;
  localparam logic [7:0] OFS_CTRL  = 8'h50;
  localparam logic [7:0] OFS_IEN   = 8'h54;
  localparam logic [7:0] OFS_STAT  = 8'h58;
  localparam logic [7:0] OFS_ACK   = 8'h5C;

  localparam int CTRL_EN_BIT  = 10;
  localparam int CTRL_PSC_LSB = 4;
  localparam int FLAG_LSB     = 1;
endpackage

// File: rtl/cap_rst_sync.sv
`timescale 1ns/1ps
module cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/cap_timebase.sv
`timescale 1ns/1ps
module cap_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] count
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] div_d;
  logic [CNT_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    tick  = (div_q >= psc);
    div_d = tick ? '0 : div_q + PSC_W'(1);
    cnt_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      count <= '0;
    end else begin
      div_q <= div_d;
      if (tick) begin
        count <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/cap_channel.sv
`timescale 1ns/1ps
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic             arm,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [CNT_W-1:0] value
);
  logic [SYNC_N-1:0] sync_q;
  logic [SYNC_N-1:0] sync_d;
  logic              prev_q;
  logic              rise;
  logic              fall;
  logic              want;

  always_comb begin
    sync_d = {sync_q[SYNC_N-2:0], cap_in};
    rise   = sync_q[SYNC_N-1] & ~prev_q;
    fall   = ~sync_q[SYNC_N-1] & prev_q;
    unique case (edge_sel_e'(mode))
      EDGE_RISE: want = rise;
      EDGE_FALL: want = fall;
      EDGE_BOTH: want = rise | fall;
      default:   want = 1'b0;
    endcase
    hit = arm & want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (hit) begin
      value <= count;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
`timescale 1ns/1ps
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 5,
  parameter int SYNC_N = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int FLAG_MSB = FLAG_LSB + NUM_CH - 1;

  logic                          sys_rst_n;
  logic                          cap_en_q, cap_en_d;
  logic [PSC_W-1:0]              psc_q, psc_d;
  logic [NUM_CH-1:0]             ien_q, ien_d;
  logic [NUM_CH-1:0]             stat_q, stat_d;
  logic [NUM_CH-1:0][1:0]        mode_q, mode_d;
  logic [NUM_CH-1:0]             wr_edge;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0][CNT_W-1:0]  cap_val;
  logic [CNT_W-1:0]              count;
  logic                          wr_ctrl, wr_ien, ack_wr;
  logic [NUM_CH-1:0]             ack_mask;
  logic                          unused_wdata;

  cap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(sys_rst_n)
  );

  cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(sys_rst_n), .psc(psc_q), .count(count)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_edge[i] = bus_we && (bus_addr == ADDR_W'(OFS_EDGE + 8'(4 * i)));

    cap_channel #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_ch (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .cap_in(cap_in[i]),
      .arm   (cap_en_q),
      .mode  (mode_q[i]),
      .count (count),
      .hit   (hit[i]),
      .value (cap_val[i])
    );
  end

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_ien   = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    ack_wr   = bus_we && (bus_addr == ADDR_W'(OFS_ACK));
    ack_mask = bus_wdata[FLAG_MSB:FLAG_LSB];

    cap_en_d = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : cap_en_q;
    psc_d    = wr_ctrl ? bus_wdata[CTRL_PSC_LSB +: PSC_W] : psc_q;
    ien_d    = wr_ien ? bus_wdata[FLAG_MSB:FLAG_LSB] : ien_q;
    stat_d   = (stat_q & ~(ack_wr ? ack_mask : '0)) | hit;
    for (int i = 0; i < NUM_CH; i++) begin
      mode_d[i] = wr_edge[i] ? bus_wdata[1:0] : mode_q[i];
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      cap_en_q <= 1'b0;
      psc_q    <= '0;
      ien_q    <= '0;
      stat_q   <= '0;
      mode_q   <= '0;
    end else begin
      cap_en_q <= cap_en_d;
      psc_q    <= psc_d;
      ien_q    <= ien_d;
      stat_q   <= stat_d;
      mode_q   <= mode_d;
    end
  end

  assign irq = |(stat_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      bus_rdata[CTRL_EN_BIT]            = cap_en_q;
      bus_rdata[CTRL_PSC_LSB +: PSC_W]  = psc_q;
    end
    if (bus_addr == ADDR_W'(OFS_IEN)) begin
      bus_rdata[FLAG_MSB:FLAG_LSB] = ien_q;
    end
    if (bus_addr == ADDR_W'(OFS_STAT)) begin
      bus_rdata[FLAG_MSB:FLAG_LSB] = stat_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(OFS_VALUE + 8'(4 * i))) begin
        bus_rdata = DATA_W'(cap_val[i]);
      end
      if (bus_addr == ADDR_W'(OFS_EDGE + 8'(4 * i))) begin
        bus_rdata[1:0] = mode_q[i];
      end
    end
  end
endmodule

// File: rtl/cap_checker.sv
`timescale 1ns/1ps
module cap_checker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [CNT_W-1:0]             count,
  input logic [NUM_CH-1:0]            hit,
  input logic [NUM_CH-1:0]            stat,
  input logic                         cap_en,
  input logic [NUM_CH-1:0][1:0]       mode,
  input logic [NUM_CH-1:0][CNT_W-1:0] value,
  input logic                         ack_wr,
  input logic [NUM_CH-1:0]            ack_mask
);
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count) |-> count == $past(count) + CNT_W'(1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_value_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hit[i]) |-> $stable(value[i]));

    p_flag_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[i]) |-> ($past(cap_en) && $past(mode[i]) != 2'b00));

    p_flag_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[i]) |-> $past(hit[i]));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ack_wr && ack_mask[i] && !hit[i]) |-> !stat[i]);

    p_hit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hit[i]) |-> stat[i]);
  end
endmodule

bind edge_capture_unit cap_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (sys_rst_n),
  .count   (count),
  .hit     (hit),
  .stat    (stat_q),
  .cap_en  (cap_en_q),
  .mode    (mode_q),
  .value   (cap_val),
  .ack_wr  (ack_wr),
  .ack_mask(ack_mask)
);

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  cap_in;
  logic            bus_we;
  logic [7:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            irq;

  int n_chk = 0;
  int n_bad = 0;
  int mpsc  = 0;
  int mdiv  = 0;
  logic [CW-1:0]   mcnt = '0;
  logic            mr1 = 1'b0, mr2 = 1'b0;
  logic [NCH-1:0]  lvl = '0;
  logic [NCH-1:0]  mien = '0;
  logic [31:0]     expval [NCH];

  edge_capture_unit #(.NUM_CH(NCH), .CNT_W(CW), .PSC_W(5)) dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // Independent counter model: internal reset follows rst_n by two edges (R1),
  // one increment every (psc+1) cycles (R3).
  always @(posedge clk) begin
    mr1 <= rst_n;
    mr2 <= mr1 & rst_n;
    if (!rst_n) begin
      mr1 <= 1'b0;
      mr2 <= 1'b0;
    end
    if (!mr2 || !rst_n) begin
      mdiv <= 0;
      mcnt <= '0;
    end else if (mdiv >= mpsc) begin
      mdiv <= 0;
      mcnt <= mcnt + 1'b1;
    end else begin
      mdiv <= mdiv + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h50) mpsc = int'(d[8:4]);
    if (a == 8'h54) mien = d[NCH:1];
  endtask

  // Change one input and check latency, timestamp, flags and irq.
  task automatic toggle(input int ch, input logic lv, input logic exp_hit, input string tag);
    logic [31:0] d, s0, es;
    logic [CW-1:0] stamp;
    rd(8'h58, s0);
    cap_in[ch] = lv;
    lvl[ch] = lv;
    cyc(2);
    stamp = mcnt;
    rd(8'h58, d);
    check($sformatf("R2 %s ch%0d flags after two edges", tag, ch), d, s0);
    cyc(1);
    if (exp_hit) expval[ch] = 32'(stamp);
    rd(8'h10 + 8'(4 * ch), d);
    check($sformatf("R4 %s ch%0d capture value", tag, ch), d, expval[ch]);
    es = exp_hit ? (s0 | (32'd1 << (ch + 1))) : s0;
    rd(8'h58, d);
    check($sformatf("R7 R10 %s ch%0d flags", tag, ch), d, es);
    check($sformatf("R8 %s ch%0d irq", tag, ch), 32'(irq), 32'(|(es[NCH:1] & mien)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, v1;
    rst_n = 1'b0; cap_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < NCH; i++) expval[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    rd(8'h50, d); check("R1 ctrl", d, 0);
    rd(8'h54, d); check("R1 enables", d, 0);
    rd(8'h58, d); check("R1 flags", d, 0);
    check("R1 irq", 32'(irq), 0);
    for (int i = 0; i < NCH; i++) begin
      rd(8'h10 + 8'(4 * i), d); check($sformatf("R1 value ch%0d", i), d, 0);
      rd(8'h30 + 8'(4 * i), d); check($sformatf("R1 mode ch%0d", i), d, 0);
    end

    // Enable, no prescale, all interrupts
    wr(8'h50, 32'h400);
    rd(8'h50, d); check("R3 R6 ctrl readback", d, 32'h400);
    wr(8'h54, 32'h1E);
    rd(8'h54, d); check("R8 enables readback", d, 32'h1E);

    // R5 exhaustive mode x direction sweep on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 4; m++) begin
        wr(8'h30 + 8'(4 * ch), 32'(m));
        rd(8'h30 + 8'(4 * ch), d); check($sformatf("R5 mode readback ch%0d", ch), d, 32'(m));
        for (int k = 0; k < 2; k++) begin
          logic nl;
          nl = ~lvl[ch];
          toggle(ch, nl, (nl && m[0]) || (!nl && m[1]), $sformatf("R5 mode%0d", m));
          wr(8'h5C, 32'h1FF);
          rd(8'h58, d); check("R7 ack all", d, 0);
          check("R8 irq after ack", 32'(irq), 0);
        end
      end
    end

    // R3 prescale sweep: a gap of k*(p+1) cycles spans exactly k ticks (mod 2^CW)
    begin
      int ps [5] = '{0, 1, 2, 5, 31};
      int ks [5] = '{300, 10, 7, 3, 2};
      for (int t = 0; t < 5; t++) begin
        wr(8'h50, 32'h400 | (32'(ps[t]) << 4));
        wr(8'h34, 32'd3);
        toggle(1, ~lvl[1], 1'b1, "R3 gap start");
        v1 = expval[1];
        wr(8'h5C, 32'h1FF);
        cyc(ks[t] * (ps[t] + 1) - 4);
        toggle(1, ~lvl[1], 1'b1, "R3 gap end");
        check($sformatf("R3 tick count psc=%0d", ps[t]),
              32'((expval[1] - v1) & 32'hFF), 32'(ks[t] % 256));
        wr(8'h5C, 32'h1FF);
      end
    end
    wr(8'h50, 32'h400);

    // R6 master enable off: no capture
    wr(8'h50, 32'h0);
    wr(8'h30, 32'd3);
    toggle(0, ~lvl[0], 1'b0, "R6 disabled");
    toggle(0, ~lvl[0], 1'b0, "R6 disabled");
    wr(8'h50, 32'h400);

    // R8 masking: flag set, irq held low until enable written
    wr(8'h54, 32'h0);
    toggle(2, ~lvl[2], 1'b1, "R8 masked");
    wr(8'h54, 32'h08);
    check("R8 irq after unmask", 32'(irq), 1);
    wr(8'h54, 32'h10);
    check("R8 irq other channel enable", 32'(irq), 0);
    wr(8'h54, 32'h1E);
    wr(8'h5C, 32'h1FF);

    // R9 capture on the same edge as acknowledge
    wr(8'h38, 32'd3);
    rd(8'h58, d); check("R9 flags clear before", d, 0);
    cap_in[2] = ~lvl[2];
    lvl[2] = ~lvl[2];
    cyc(2);
    v1 = 32'(mcnt);
    bus_we = 1'b1; bus_addr = 8'h5C; bus_wdata = 32'h1FF;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    rd(8'h58, d); check("R9 capture beats ack", d, 32'h08);
    rd(8'h18, d); check("R9 value", d, v1);
    expval[2] = v1;

    // R7 partial acknowledge, R10 independence
    wr(8'h3C, 32'd1);
    toggle(3, 1'b1, ~lvl[3], "R10 second channel");
    wr(8'h5C, 32'h08);
    rd(8'h58, d); check("R7 partial ack keeps other", d, (lvl[3] ? 32'h10 : 32'h0));
    rd(8'h18, d); check("R10 ch2 value untouched", d, expval[2]);

    summary();
    $finish;
  end
endmodule